// File: doc/BRIEF.md
# Nested Exception Priority Controller

This block chooses which pending exception a processor core takes next and decides whether it may preempt the handler that is running now. Three exceptions have fixed ranks: Reset, NMI and HardFault. A parameterised set of further exceptions takes 8-bit priorities that are written through a small configuration port. The block keeps a stack of the priorities of the active handlers. From that stack it derives the current execution priority, and a pending exception is taken only when its priority is strictly higher.

Once the block has issued a take, it follows the entry sequence. An exception of strictly higher priority that arrives before the vector-fetch point takes over that entry, and a redirect strobe reports it. This covers a fault raised by the entry's own stacking, which is presented as a pending HardFault. After the vector fetch a new arrival waits until entry has completed. When the current multi-word load or store has been marked as not interruptible, the block holds back new takes until that transfer ends.

The pins are plain control and status pins. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure. Stacking, the vector fetch and clearing the pending sources are the job of the surrounding core.

Top module: `exc_nest_ctrl`

## Requirements
- R1: Exceptions are numbered 1 for Reset, 2 for NMI, 3 for HardFault and 4 to 3+NCFG for the configurable ones. Bit k of `pend_i` requests exception k+1. The three fixed exceptions rank -3, -2 and -1 in that order, which is above every configurable priority.
- R2: A cycle with `cfg_we_i` high and `cfg_sel_i` below NCFG sets the priority of exception 4+`cfg_sel_i` to `cfg_prio_i`. Every configurable priority is 0 after reset. A smaller value means a higher priority.
- R3: Among the pending exceptions the one with the smallest priority value wins. When several share that value, the one with the smallest exception number wins.
- R4: A take happens when no entry is in progress and the winner's priority is strictly below the execution priority. In the cycle after the deciding clock edge, `take_o` is high for one cycle with `take_num_o`, and `entry_busy_o` is high from that cycle on. An equal priority never preempts.
- R5: `exec_prio_o` is a two's-complement value PRIO_W+2 bits wide. It equals the smallest priority on the active stack, or 2^PRIO_W (256 by default) when the stack is empty, and it reads 256 after reset.
- R6: `entry_done_i` during an entry ends the entry and pushes that entry's priority onto the stack. `exc_return_i` pops the most recent entry. It is ignored while an entry is in progress or when the stack is empty.
- R7: During an entry, before the vector-fetch point, a winner whose priority is strictly higher than the entry's takes over the entry. `redirect_o` is then high for one cycle with `redirect_num_o`, and the entry continues with the new exception's priority.
- R8: Once `vec_fetch_i` has been seen in an entry, no redirect happens until the entry completes. After completion, the waiting exception is taken through the normal R4 rule.
- R9: While `xfer_busy_i` is high and `xfer_intr_en_i` is low, no take is issued. When `xfer_intr_en_i` is high, `xfer_busy_i` has no effect.
- R10: While the stack holds DEPTH entries, no take is issued. One pop makes room again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NCFG+3 | Pending request lines, bit k is exception k+1 |
| cfg_we_i | input | 1 | Priority write strobe |
| cfg_sel_i | input | clog2(NCFG)+1 | Configurable exception index (exception 4+sel) |
| cfg_prio_i | input | PRIO_W | Priority value to write |
| xfer_busy_i | input | 1 | A multi-word load/store is executing |
| xfer_intr_en_i | input | 1 | That transfer may be interrupted |
| vec_fetch_i | input | 1 | Entry has reached the vector-fetch point |
| entry_done_i | input | 1 | Entry sequence complete, handler starts |
| exc_return_i | input | 1 | Handler returns |
| take_o | output | 1 | One-cycle take strobe |
| take_num_o | output | clog2(NCFG+4) | Number of the taken exception |
| redirect_o | output | 1 | One-cycle late-arrival strobe |
| redirect_num_o | output | clog2(NCFG+4) | Number of the exception now being entered |
| entry_busy_o | output | 1 | Entry in progress |
| exec_prio_o | output | PRIO_W+2 | Current execution priority, signed |

## Verification
On every cycle, the assertions check that a take strobe lasts one cycle and begins an entry, and that no take follows a cycle in which a non-interruptible transfer was busy. They also check that a redirect occurs only inside an entry and never right after a vector fetch. For the stack, they check that completing an entry strictly lowers the execution priority and that a pop strictly raises it. The bench scenarios are needed for the rest: arbitration order across fixed and configured priorities, tie-breaking by exception number, the exact numbers taken and redirected, and the sequences of push, pop and a full stack.

// File: rtl/exc_nest_pkg.sv
package exc_nest_pkg;
  localparam int NUM_FIXED     = 3;
  localparam int EXC_RESET     = 1;
  localparam int EXC_NMI       = 2;
  localparam int EXC_HARDFAULT = 3;
endpackage

// File: rtl/exc_prio_regs.sv
module exc_prio_regs #(
  parameter int NCFG   = 8,
  parameter int PRIO_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [PRIO_W-1:0] wdata,
  output logic [PRIO_W-1:0] prio_q [NCFG]
);
  for (genvar j = 0; j < NCFG; j++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                       prio_q[j] <= '0;
      else if (we && int'(sel) == j)    prio_q[j] <= wdata;
    end
  end
endmodule

// File: rtl/exc_rank_arb.sv
module exc_rank_arb #(
  parameter int NEXC  = 11,
  parameter int RW    = 10,
  parameter int NUM_W = 4
) (
  input  logic [NEXC-1:0]  pend,
  input  logic [RW-1:0]    rank [NEXC],
  output logic             win_v,
  output logic [NUM_W-1:0] win_num,
  output logic [RW-1:0]    win_rank
);
  // strict compare in index order: ties keep the lower exception number
  always_comb begin
    win_v    = 1'b0;
    win_num  = '0;
    win_rank = '1;
    for (int i = 0; i < NEXC; i++) begin
      if (pend[i] && (!win_v || rank[i] < win_rank)) begin
        win_v    = 1'b1;
        win_rank = rank[i];
        win_num  = NUM_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/exc_active_stack.sv
module exc_active_stack #(
  parameter int            DEPTH     = 4,
  parameter int            RW        = 10,
  parameter logic [RW-1:0] IDLE_RANK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [RW-1:0] push_rank,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [RW-1:0] exec_rank
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic [RW-1:0] rank_q [DEPTH];

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (push && !full)    cnt <= cnt + 1'b1;
    else if (pop && !empty)    cnt <= cnt - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                               rank_q[i] <= IDLE_RANK;
      else if (push && !full && cnt == CW'(i))  rank_q[i] <= push_rank;
    end
  end

  always_comb begin
    exec_rank = IDLE_RANK;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt && rank_q[i] < exec_rank) exec_rank = rank_q[i];
    end
  end
endmodule

// File: rtl/exc_nest_ctrl.sv
module exc_nest_ctrl
  import exc_nest_pkg::*;
#(
  parameter  int NCFG   = 8,
  parameter  int PRIO_W = 8,
  parameter  int DEPTH  = 4,
  localparam int NEXC   = NCFG + NUM_FIXED,
  localparam int NUM_W  = $clog2(NEXC + 1),
  localparam int SEL_W  = $clog2(NCFG) + 1,
  localparam int RW     = PRIO_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NEXC-1:0]      pend_i,
  input  logic                 cfg_we_i,
  input  logic [SEL_W-1:0]     cfg_sel_i,
  input  logic [PRIO_W-1:0]    cfg_prio_i,
  input  logic                 xfer_busy_i,
  input  logic                 xfer_intr_en_i,
  input  logic                 vec_fetch_i,
  input  logic                 entry_done_i,
  input  logic                 exc_return_i,
  output logic                 take_o,
  output logic [NUM_W-1:0]     take_num_o,
  output logic                 redirect_o,
  output logic [NUM_W-1:0]     redirect_num_o,
  output logic                 entry_busy_o,
  output logic signed [RW-1:0] exec_prio_o
);
  // internal rank = priority + NUM_FIXED, so Reset/NMI/HardFault are 0/1/2
  localparam logic [RW-1:0] IDLE_RANK = RW'(NUM_FIXED + 2**PRIO_W);

  logic [PRIO_W-1:0] prio_q [NCFG];
  logic [RW-1:0]     rank   [NEXC];
  logic              win_v;
  logic [NUM_W-1:0]  win_num;
  logic [RW-1:0]     win_rank;
  logic              stk_full, stk_empty;
  logic [RW-1:0]     exec_rank;

  logic              busy_q, past_vec_q;
  logic [RW-1:0]     erank_q;
  logic              take_q, redir_q;
  logic [NUM_W-1:0]  tnum_q, rnum_q;

  exc_prio_regs #(.NCFG(NCFG), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .sel(cfg_sel_i),
    .wdata(cfg_prio_i), .prio_q(prio_q)
  );

  for (genvar i = 0; i < NEXC; i++) begin : g_rank
    if (i < NUM_FIXED) begin : g_fix
      assign rank[i] = RW'(i);
    end else begin : g_cfg
      assign rank[i] = RW'(prio_q[i-NUM_FIXED]) + RW'(NUM_FIXED);
    end
  end

  exc_rank_arb #(.NEXC(NEXC), .RW(RW), .NUM_W(NUM_W)) u_arb (
    .pend(pend_i), .rank(rank),
    .win_v(win_v), .win_num(win_num), .win_rank(win_rank)
  );

  logic lock, take_c, redir_c, push, pop;
  assign lock    = xfer_busy_i & ~xfer_intr_en_i;
  assign take_c  = ~busy_q & win_v & (win_rank < exec_rank) & ~lock & ~stk_full;
  assign redir_c = busy_q & ~past_vec_q & ~vec_fetch_i & ~entry_done_i &
                   win_v & (win_rank < erank_q);
  assign push    = busy_q & entry_done_i;
  assign pop     = exc_return_i & ~busy_q & ~stk_empty;

  exc_active_stack #(.DEPTH(DEPTH), .RW(RW), .IDLE_RANK(IDLE_RANK)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .push_rank(erank_q), .pop(pop),
    .full(stk_full), .empty(stk_empty), .exec_rank(exec_rank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      past_vec_q <= 1'b0;
      erank_q    <= IDLE_RANK;
      take_q     <= 1'b0;
      redir_q    <= 1'b0;
      tnum_q     <= '0;
      rnum_q     <= '0;
    end else begin
      take_q  <= take_c;
      redir_q <= redir_c;
      if (take_c) begin
        busy_q     <= 1'b1;
        past_vec_q <= 1'b0;
        erank_q    <= win_rank;
        tnum_q     <= win_num;
      end else if (busy_q) begin
        if (entry_done_i) begin
          busy_q     <= 1'b0;
          past_vec_q <= 1'b0;
        end else begin
          if (redir_c) begin
            erank_q <= win_rank;
            rnum_q  <= win_num;
          end
          if (vec_fetch_i) past_vec_q <= 1'b1;
        end
      end
    end
  end

  assign take_o         = take_q;
  assign take_num_o     = tnum_q;
  assign redirect_o     = redir_q;
  assign redirect_num_o = rnum_q;
  assign entry_busy_o   = busy_q;
  assign exec_prio_o    = $signed(exec_rank - RW'(NUM_FIXED));
endmodule

// File: rtl/exc_nest_ctrl_chk.sv
module exc_nest_ctrl_chk #(
  parameter int NCFG   = 8,
  parameter int PRIO_W = 8,
  parameter int NUM_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   xfer_busy_i,
  input logic                   xfer_intr_en_i,
  input logic                   vec_fetch_i,
  input logic                   entry_done_i,
  input logic                   exc_return_i,
  input logic                   take_o,
  input logic [NUM_W-1:0]       take_num_o,
  input logic                   redirect_o,
  input logic                   entry_busy_o,
  input logic signed [PRIO_W+1:0] exec_prio_o
);
  localparam int NEXC   = NCFG + 3;
  localparam int IDLE_P = 2**PRIO_W;

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o); // R4
  AST_TAKE_BEGINS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> entry_busy_o); // R4
  AST_TAKE_NUM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (take_num_o != '0 && int'(take_num_o) <= NEXC)); // R1
  AST_HOLD_ON_LOCKED_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy_i && !xfer_intr_en_i) |=> !take_o); // R9
  AST_REDIR_INSIDE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (entry_busy_o && !take_o)); // R7
  AST_NO_REDIR_AFTER_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch_i |=> !redirect_o); // R8
  AST_PUSH_LOWERS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_done_i && entry_busy_o) |=> ($signed(exec_prio_o) < $signed($past(exec_prio_o)))); // R6
  AST_POP_RAISES_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return_i && !entry_busy_o && int'(exec_prio_o) != IDLE_P)
      |=> ($signed(exec_prio_o) > $signed($past(exec_prio_o)))); // R6
endmodule

bind exc_nest_ctrl exc_nest_ctrl_chk #(.NCFG(NCFG), .PRIO_W(PRIO_W), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_busy_i(xfer_busy_i), .xfer_intr_en_i(xfer_intr_en_i),
  .vec_fetch_i(vec_fetch_i), .entry_done_i(entry_done_i), .exc_return_i(exc_return_i),
  .take_o(take_o), .take_num_o(take_num_o), .redirect_o(redirect_o),
  .entry_busy_o(entry_busy_o), .exec_prio_o(exec_prio_o)
);

// File: tb/exc_nest_ctrl_bench.sv
module exc_nest_ctrl_bench;
  localparam int NCFG = 8, PRIO_W = 8, DEPTH = 4;
  localparam int NEXC = NCFG + 3, NUM_W = 4, SEL_W = 4, RW = PRIO_W + 2;
  localparam int IDLE_R = 3 + 256;

  logic clk = 0, rst_n = 0;
  logic [NEXC-1:0] pend = '0;
  logic cfg_we = 0; logic [SEL_W-1:0] cfg_sel = '0; logic [PRIO_W-1:0] cfg_prio = '0;
  logic xbusy = 0, xen = 0, vec = 0, edone = 0, eret = 0;
  logic take_o, redirect_o, entry_busy_o;
  logic [NUM_W-1:0] take_num_o, redirect_num_o;
  logic signed [RW-1:0] exec_prio_o;

  int total = 0, bad = 0;

  // bench model state
  int m_prio [NCFG];
  int m_stk [DEPTH];
  int m_cnt, m_erank, m_tnum, m_rnum;
  bit m_busy, m_past, m_take, m_redir;

  always #4 clk = ~clk;

  exc_nest_ctrl u_exc_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_prio_i(cfg_prio), .xfer_busy_i(xbusy), .xfer_intr_en_i(xen),
    .vec_fetch_i(vec), .entry_done_i(edone), .exc_return_i(eret),
    .take_o(take_o), .take_num_o(take_num_o), .redirect_o(redirect_o),
    .redirect_num_o(redirect_num_o), .entry_busy_o(entry_busy_o), .exec_prio_o(exec_prio_o)
  );

  function automatic int mrank(int i);
    return (i < 3) ? i : 3 + m_prio[i-3];
  endfunction

  function automatic int mexec();
    int r = IDLE_R;
    for (int i = 0; i < m_cnt; i++) if (m_stk[i] < r) r = m_stk[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit wv = 0; int wr = 0, wn = 0, ex;
    bit tc, rc, pop;
    for (int i = 0; i < NEXC; i++)
      if (pend[i] && (!wv || mrank(i) < wr)) begin wv = 1; wr = mrank(i); wn = i + 1; end
    ex  = mexec();
    tc  = !m_busy && wv && wr < ex && !(xbusy && !xen) && m_cnt < DEPTH;
    rc  = m_busy && !m_past && !vec && !edone && wv && wr < m_erank;
    pop = eret && !m_busy && m_cnt > 0;
    @(posedge clk); #1;
    m_take = tc; m_redir = rc;
    if (pop) m_cnt--;
    if (tc) begin
      m_busy = 1; m_past = 0; m_erank = wr; m_tnum = wn;
    end else if (m_busy) begin
      if (edone) begin
        m_stk[m_cnt] = m_erank; m_cnt++; m_busy = 0; m_past = 0;
      end else begin
        if (rc) begin m_erank = wr; m_rnum = wn; end
        if (vec) m_past = 1;
      end
    end
    if (cfg_we && int'(cfg_sel) < NCFG) m_prio[cfg_sel] = int'(cfg_prio);
    chk(take_o == m_take, "R4 take strobe", take_o, m_take);
    if (m_take) chk(int'(take_num_o) == m_tnum, "R3 taken number", take_num_o, m_tnum);
    chk(redirect_o == m_redir, "R7 redirect strobe", redirect_o, m_redir);
    if (m_redir) chk(int'(redirect_num_o) == m_rnum, "R7 redirect number", redirect_num_o, m_rnum);
    chk(entry_busy_o == m_busy, "R4 entry busy", entry_busy_o, m_busy);
    chk(int'(exec_prio_o) == mexec() - 3, "R5 exec priority", exec_prio_o, mexec() - 3);
  endtask

  task automatic cfg_write(input int sel, input int val);
    cfg_we = 1; cfg_sel = SEL_W'(sel); cfg_prio = PRIO_W'(val);
    step();
    cfg_we = 0;
  endtask

  task automatic finish_entry();
    vec = 1; step(); vec = 0;
    edone = 1; step(); edone = 0;
  endtask

  task automatic do_entry(input int n);
    pend[n-1] = 1'b1; step();
    chk(take_o && int'(take_num_o) == n, "R4 directed take", take_num_o, n);
    pend[n-1] = 1'b0;
    finish_entry();
  endtask

  task automatic pop_all();
    pend = '0;
    repeat (DEPTH + 1) begin eret = 1; step(); eret = 0; end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NCFG; i++) m_prio[i] = 0;
    for (int i = 0; i < DEPTH; i++) m_stk[i] = IDLE_R;
    m_cnt = 0; m_busy = 0; m_past = 0; m_erank = IDLE_R; m_take = 0; m_redir = 0;
    m_tnum = 0; m_rnum = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    chk(!take_o && !entry_busy_o, "R4 reset idle", take_o, 0);
    chk(int'(exec_prio_o) == 256, "R5 reset exec priority", exec_prio_o, 256);

    // R1: fixed exceptions outrank even a configurable priority of 0
    pend = 11'b000_0000_1111; step();
    chk(take_o && take_num_o == 4'd1, "R1 reset wins", take_num_o, 1);
    pend = '0; finish_entry(); pop_all();

    // R2/R3: configured values and tie by exception number
    cfg_write(0, 5); cfg_write(1, 5); cfg_write(2, 3);
    pend = 11'b000_0001_1000; step();
    chk(take_o && take_num_o == 4'd4, "R3 tie lowest number", take_num_o, 4);
    pend = 11'b000_0001_0000; finish_entry();
    chk(int'(exec_prio_o) == 5, "R2 configured priority on stack", exec_prio_o, 5);
    step();
    chk(!take_o, "R4 equal priority does not preempt", take_o, 0);

    // R7: fault during entry redirects; R8: no redirect after vector fetch
    pend = 11'b000_0010_0000; step();
    chk(take_o && take_num_o == 4'd6, "R4 higher priority preempts", take_num_o, 6);
    pend = 11'b000_0000_0100; step();
    chk(redirect_o && redirect_num_o == 4'd3, "R7 late HardFault", redirect_num_o, 3);
    pend = '0; vec = 1; step(); vec = 0;
    pend = 11'b000_0000_0010; step();
    chk(!redirect_o, "R8 no redirect after vector fetch", redirect_o, 0);
    edone = 1; step(); edone = 0;
    chk(int'(exec_prio_o) == -1, "R6 push HardFault", exec_prio_o, -1);
    step();
    chk(take_o && take_num_o == 4'd2, "R8 waiting NMI taken after entry", take_num_o, 2);
    pend = '0; finish_entry();
    chk(int'(exec_prio_o) == -2, "R1 NMI rank", exec_prio_o, -2);
    eret = 1; step(); eret = 0;
    chk(int'(exec_prio_o) == -1, "R6 pop", exec_prio_o, -1);
    eret = 1; step(); eret = 0;
    chk(int'(exec_prio_o) == 5, "R6 second pop", exec_prio_o, 5);
    eret = 1; step(); eret = 0;
    chk(int'(exec_prio_o) == 256, "R6 back to thread", exec_prio_o, 256);
    eret = 1; step(); eret = 0;
    chk(int'(exec_prio_o) == 256, "R6 pop on empty ignored", exec_prio_o, 256);

    // R9: non-interruptible transfer holds the take
    pend = 11'b000_0000_1000; xbusy = 1; xen = 0; step();
    chk(!take_o, "R9 hold during locked transfer", take_o, 0);
    step();
    chk(!take_o, "R9 still held", take_o, 0);
    xen = 1; step();
    chk(take_o && take_num_o == 4'd4, "R9 interruptible transfer", take_num_o, 4);
    pend = '0; xbusy = 0; xen = 0; finish_entry(); pop_all();

    // R10: full stack blocks takes
    cfg_write(0, 200); cfg_write(1, 100); cfg_write(2, 50); cfg_write(3, 20); cfg_write(4, 10);
    do_entry(4); do_entry(5); do_entry(6); do_entry(7);
    pend = 11'b000_1000_0000; step();
    chk(!take_o, "R10 full stack blocks take", take_o, 0);
    eret = 1; step(); eret = 0;
    chk(!take_o, "R10 pop cycle", take_o, 0);
    step();
    chk(take_o && take_num_o == 4'd8, "R10 take after room", take_num_o, 8);
    pend = '0; finish_entry(); pop_all();

    // constrained random traffic against the bench model
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < NEXC; b++) pend[b] = ($urandom_range(0, 15) == 0);
      cfg_we   = ($urandom_range(0, 7) == 0);
      cfg_sel  = SEL_W'($urandom_range(0, 15));
      cfg_prio = PRIO_W'($urandom_range(0, 255));
      xbusy    = ($urandom_range(0, 3) == 0);
      xen      = ($urandom_range(0, 1) == 0);
      vec      = ($urandom_range(0, 3) == 0);
      edone    = ($urandom_range(0, 4) == 0);
      eret     = ($urandom_range(0, 5) == 0);
      step();
    end
    summary();
    $finish;
  end
endmodule